// File: doc/BRIEF.md
# Register Status Rename Table

This block is the architectural register file of an out-of-order issue engine. Each register holds a data value paired with a producer tag. A tag of zero marks the value as current. A nonzero tag names the reservation station that will produce the register's next value.

When an instruction issues, the block does three things:

- It looks up two source registers through two independent combinational read ports. Each port returns either a ready value or the tag of the pending producer. The caller stores that tag in its reservation station.
- It records, through the rename port, that the destination register will now be produced by the newly allocated station.
- It snoops the result broadcast bus. Any register still waiting on the broadcast tag captures the value and becomes ready.

A register is written only by a tag-matched broadcast. A later rename therefore supersedes an earlier pending producer, and a late result from that older producer is ignored. This removes write-after-write and write-after-read hazards.

All data inputs are single-cycle transfers qualified by a valid bit. The table accepts a rename and a broadcast in every cycle. It never applies back-pressure, so no ready handshake exists on these inputs. The read ports are combinational lookups with no handshake. Tag zero is reserved and is never a producer name.

Top module: `rename_status_table`

## Requirements
- R1: After reset, every register reads as ready (ready=1) with tag 0 and value 0.
- R2: A read of a register whose stored tag is 0 returns ready=1, tag 0 and the stored value in the same cycle.
- R3: A read of a register waiting on a producer returns ready=0, the producer tag, and value 0. This holds unless R7 applies.
- R4: A rename (ren_valid=1, nonzero ren_tag) sets the destination register's tag from the next cycle on and leaves its value unchanged. A read in the rename cycle still sees the prior state.
- R5: A broadcast with bc_valid=1 and a nonzero bc_tag equal to a register's stored tag writes bc_value into that register and clears its tag. The update is visible from the next cycle.
- R6: After a register has been renamed to a newer tag, a broadcast of its older producer tag leaves both its value and its tag unchanged.
- R7: A read in the same cycle as a broadcast matching the register's stored tag returns ready=1, tag 0 and the broadcast value.
- R8: When a rename and a matching broadcast hit the same register in one cycle, the register takes the new tag and keeps its old value.
- R9: One broadcast updates every register waiting on its tag.
- R10: A broadcast with bc_valid=0, or with bc_tag=0, changes no register.
- R11: The two read ports are independent and may address the same or different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd0_addr | input | ADDR_W | Source register for read port 0 |
| rd0_ready | output | 1 | Port 0 result is a value |
| rd0_tag | output | TAG_W | Port 0 producer tag (0 when ready) |
| rd0_value | output | DATA_W | Port 0 value (0 when not ready) |
| rd1_addr | input | ADDR_W | Source register for read port 1 |
| rd1_ready | output | 1 | Port 1 result is a value |
| rd1_tag | output | TAG_W | Port 1 producer tag (0 when ready) |
| rd1_value | output | DATA_W | Port 1 value (0 when not ready) |
| ren_valid | input | 1 | Rename request valid |
| ren_addr | input | ADDR_W | Destination register to rename |
| ren_tag | input | TAG_W | New producer tag, nonzero |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcasting producer |
| bc_value | input | DATA_W | Broadcast result value |

## Verification
The bench builds the block with its defaults: 16 registers, 32-bit data and 4-bit tags. With only 15 producer names spread over 16 registers, random traffic often leaves several registers waiting on the same tag. It also makes renames collide with same-tag broadcasts and reads coincide with matching broadcasts. These are the multi-hit (R9), stale-producer (R6) and bypass (R7) cases. Directed sequences pin down the same-cycle rename-versus-broadcast ordering and the ignored broadcasts.

// File: rtl/rst_pkg.sv
package rst_pkg;
  localparam int unsigned DEF_NUM_REGS = 16;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_TAG_W    = 4;
  localparam int unsigned NO_TAG       = 0;

  typedef enum logic [0:0] {
    SRC_PENDING = 1'b0,
    SRC_READY   = 1'b1
  } src_state_e;
endpackage

// File: rtl/rst_entry.sv
module rst_entry #(
  parameter int unsigned DATA_W = rst_pkg::DEF_DATA_W,
  parameter int unsigned TAG_W  = rst_pkg::DEF_TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_hit,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  output logic [DATA_W-1:0] value,
  output logic [TAG_W-1:0]  tag
);
  logic snoop_hit;

  assign snoop_hit = bc_valid && (tag != TAG_W'(rst_pkg::NO_TAG)) && (tag == bc_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      tag   <= '0;
    end else if (ren_hit) begin
      tag <= ren_tag;
    end else if (snoop_hit) begin
      value <= bc_value;
      tag   <= '0;
    end
  end

  // R5
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_tag != '0 && tag == bc_tag && !ren_hit)
      |=> (tag == '0 && value == $past(bc_value)));

  // R8
  rename_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_hit |=> (tag == $past(ren_tag) && value == $past(value)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren_hit && !(bc_valid && bc_tag != '0 && tag == bc_tag))
      |=> ($stable(tag) && $stable(value)));
endmodule

// File: rtl/rst_read_port.sv
module rst_read_port #(
  parameter int unsigned NUM_REGS = rst_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = rst_pkg::DEF_DATA_W,
  parameter int unsigned TAG_W    = rst_pkg::DEF_TAG_W,
  localparam int unsigned ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] reg_value [NUM_REGS],
  input  logic [TAG_W-1:0]  reg_tag   [NUM_REGS],
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  output logic              ready,
  output logic [TAG_W-1:0]  tag,
  output logic [DATA_W-1:0] value
);
  import rst_pkg::*;

  logic [DATA_W-1:0] sel_value;
  logic [TAG_W-1:0]  sel_tag;
  src_state_e        state;
  logic              bypass;

  always_comb begin
    sel_value = '0;
    sel_tag   = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) begin
        sel_value = reg_value[i];
        sel_tag   = reg_tag[i];
      end
    end
  end

  assign bypass = bc_valid && (sel_tag != '0) && (sel_tag == bc_tag);

  always_comb begin
    state = SRC_PENDING;
    tag   = sel_tag;
    value = '0;
    if (sel_tag == '0) begin
      state = SRC_READY;
      tag   = '0;
      value = sel_value;
    end else if (bypass) begin
      state = SRC_READY;
      tag   = '0;
      value = bc_value;
    end
  end

  assign ready = (state == SRC_READY);

  // R7
  bypass_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && sel_tag != '0 && sel_tag == bc_tag) |-> (ready && value == bc_value));

  // R3
  pending_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (value == '0 && tag != '0));
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table #(
  parameter int unsigned NUM_REGS = rst_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = rst_pkg::DEF_DATA_W,
  parameter int unsigned TAG_W    = rst_pkg::DEF_TAG_W,
  localparam int unsigned ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd0_addr,
  output logic              rd0_ready,
  output logic [TAG_W-1:0]  rd0_tag,
  output logic [DATA_W-1:0] rd0_value,
  input  logic [ADDR_W-1:0] rd1_addr,
  output logic              rd1_ready,
  output logic [TAG_W-1:0]  rd1_tag,
  output logic [DATA_W-1:0] rd1_value,
  input  logic              ren_valid,
  input  logic [ADDR_W-1:0] ren_addr,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value
);
  logic [DATA_W-1:0] reg_value [NUM_REGS];
  logic [TAG_W-1:0]  reg_tag   [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    logic hit;
    assign hit = ren_valid && (ren_addr == ADDR_W'(g));
    rst_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) i_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .ren_hit  (hit),
      .ren_tag  (ren_tag),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_value (bc_value),
      .value    (reg_value[g]),
      .tag      (reg_tag[g])
    );
  end

  rst_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_rd0 (
    .clk(clk), .rst_n(rst_n), .addr(rd0_addr),
    .reg_value(reg_value), .reg_tag(reg_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
    .ready(rd0_ready), .tag(rd0_tag), .value(rd0_value)
  );

  rst_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_rd1 (
    .clk(clk), .rst_n(rst_n), .addr(rd1_addr),
    .reg_value(reg_value), .reg_tag(reg_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
    .ready(rd1_ready), .tag(rd1_tag), .value(rd1_value)
  );

  // R4
  ren_tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid |-> (ren_tag != '0));

  // R11
  same_addr_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_addr == rd1_addr) |-> (rd0_ready == rd1_ready && rd0_tag == rd1_tag && rd0_value == rd1_value));
endmodule

// File: tb/test_rename_status_table.sv
module test_rename_status_table;
  localparam int NR = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd0_addr = '0, rd1_addr = '0;
  logic        rd0_ready, rd1_ready;
  logic [3:0]  rd0_tag, rd1_tag;
  logic [31:0] rd0_value, rd1_value;
  logic        ren_valid = 1'b0;
  logic [3:0]  ren_addr = '0, ren_tag = '0;
  logic        bc_valid = 1'b0;
  logic [3:0]  bc_tag = '0;
  logic [31:0] bc_value = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] mval [NR];
  logic [3:0]  mtag [NR];

  always #10 clk = ~clk;

  rename_status_table i_rename_status_table (
    .clk(clk), .rst_n(rst_n),
    .rd0_addr(rd0_addr), .rd0_ready(rd0_ready), .rd0_tag(rd0_tag), .rd0_value(rd0_value),
    .rd1_addr(rd1_addr), .rd1_ready(rd1_ready), .rd1_tag(rd1_tag), .rd1_value(rd1_value),
    .ren_valid(ren_valid), .ren_addr(ren_addr), .ren_tag(ren_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value)
  );

  function automatic logic [36:0] exp_read(input logic [3:0] a);
    if (mtag[a] == 4'd0) return {1'b1, 4'd0, mval[a]};
    if (bc_valid && bc_tag == mtag[a]) return {1'b1, 4'd0, bc_value};
    return {1'b0, mtag[a], 32'd0};
  endfunction

  task automatic model_update();
    for (int i = 0; i < NR; i++) begin
      if (ren_valid && ren_addr == 4'(i)) mtag[i] = ren_tag;
      else if (bc_valid && mtag[i] != 4'd0 && mtag[i] == bc_tag) begin
        mval[i] = bc_value;
        mtag[i] = 4'd0;
      end
    end
  endtask

  task automatic chk(input string req, input logic [36:0] got, input logic [36:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got rdy=%0b tag=%0d val=%h exp rdy=%0b tag=%0d val=%h",
               req, got[36], got[35:32], got[31:0], exp[36], exp[35:32], exp[31:0]);
    end
  endtask

  task automatic check_ports(input string req);
    chk(req, {rd0_ready, rd0_tag, rd0_value}, exp_read(rd0_addr));
    chk(req, {rd1_ready, rd1_tag, rd1_value}, exp_read(rd1_addr));
  endtask

  // inputs are already driven (after negedge); check, then clock and update model
  task automatic step(input string req);
    #2;
    check_ports(req);
    @(posedge clk);
    model_update();
    @(negedge clk);
    ren_valid = 1'b0;
    bc_valid  = 1'b0;
  endtask

  task automatic drive(input logic rv, input logic [3:0] ra, input logic [3:0] rt,
                       input logic bv, input logic [3:0] bt, input logic [31:0] bd,
                       input logic [3:0] a0, input logic [3:0] a1);
    ren_valid = rv; ren_addr = ra; ren_tag = rt;
    bc_valid = bv; bc_tag = bt; bc_value = bd;
    rd0_addr = a0; rd1_addr = a1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) begin mval[i] = '0; mtag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state on every register
    for (int i = 0; i < NR; i += 2) begin
      drive(0, 0, 0, 0, 0, 0, 4'(i), 4'(i + 1));
      step("R1");
    end
    // R4: rename r3 to tag 5; same-cycle read sees old state
    drive(1, 4'd3, 4'd5, 0, 0, 0, 4'd3, 4'd3);
    step("R4");
    // R3: pending read returns tag 5, value 0
    drive(0, 0, 0, 0, 0, 0, 4'd3, 4'd0);
    step("R3");
    // R7: broadcast tag 5 with read of r3 in same cycle
    drive(0, 0, 0, 1, 4'd5, 32'h0000_00AA, 4'd3, 4'd3);
    step("R7");
    // R5, R2: value now stored and ready
    drive(0, 0, 0, 0, 0, 0, 4'd3, 4'd1);
    step("R5");
    // R6: r4 renamed to 6 then 7, older tag 6 broadcast is ignored
    drive(1, 4'd4, 4'd6, 0, 0, 0, 4'd4, 4'd4); step("R6");
    drive(1, 4'd4, 4'd7, 0, 0, 0, 4'd4, 4'd4); step("R6");
    drive(0, 0, 0, 1, 4'd6, 32'hDEAD_0006, 4'd4, 4'd4); step("R6");
    drive(0, 0, 0, 0, 0, 0, 4'd4, 4'd4); step("R6");
    // R8: rename and matching broadcast on r2 in the same cycle
    drive(1, 4'd2, 4'd8, 0, 0, 0, 4'd2, 4'd2); step("R8");
    drive(1, 4'd2, 4'd9, 1, 4'd8, 32'h1234_5678, 4'd5, 4'd5); step("R8");
    drive(0, 0, 0, 0, 0, 0, 4'd2, 4'd2); step("R8");
    // R9: two registers waiting on tag 3 both capture
    drive(1, 4'd10, 4'd3, 0, 0, 0, 4'd10, 4'd11); step("R9");
    drive(1, 4'd11, 4'd3, 0, 0, 0, 4'd10, 4'd11); step("R9");
    drive(0, 0, 0, 1, 4'd3, 32'hCAFE_0003, 4'd0, 4'd1); step("R9");
    drive(0, 0, 0, 0, 0, 0, 4'd10, 4'd11); step("R9");
    // R10: invalid broadcast and tag-zero broadcast change nothing
    drive(1, 4'd12, 4'd4, 0, 0, 0, 4'd12, 4'd12); step("R10");
    drive(0, 0, 0, 0, 4'd4, 32'hBAD0_0004, 4'd0, 4'd1); step("R10");
    drive(0, 0, 0, 1, 4'd0, 32'hBAD0_0000, 4'd12, 4'd3); step("R10");
    drive(0, 0, 0, 0, 0, 0, 4'd12, 4'd3); step("R10");
    // R11: ports on different registers
    drive(0, 0, 0, 0, 0, 0, 4'd3, 4'd12); step("R11");

    // Random traffic (R2 R3 R5 R7 R9 R11)
    for (int n = 0; n < 3000; n++) begin
      drive($urandom_range(0, 1), 4'($urandom_range(0, 15)), 4'($urandom_range(1, 15)),
            $urandom_range(0, 3) != 0, 4'($urandom_range(0, 15)), $urandom,
            4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
      step("R2");
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule